// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block searches a small, fully associative translation buffer for a 32-bit virtual address. Every entry describes a pair of neighbouring 4 KB virtual pages: an even page and an odd page. The two pages share one tag and one address-space identifier. Each page has its own frame number, a valid flag and a dirty (writable) flag. All entries are compared in parallel. Virtual address bit 12 picks which half of the matching entry applies. The result is a physical address, read and write permission bits, and a result code.

Entries are loaded one at a time through an indexed write port, which replaces a whole entry on a single strobe. A request strobe starts a lookup. The search itself is combinational. A two-state controller then registers the answer: `ST_IDLE` goes to `ST_RESP` when `req` is high; `ST_RESP` stays there while `req` stays high and returns to `ST_IDLE` when it drops. The response is marked valid only while the controller is in `ST_RESP`.

Top module: `tlb_pair_lookup`

## Requirements
- R1: After reset `rsp_valid` is 0, and every entry is cleared: tag 0, identifier 0, not global, both halves with frame 0, not valid and not dirty.
- R2: The response registers are loaded on the clock edge that samples `req` high, so `rsp_valid` is 1 in the following cycle. In the cycle after an edge that samples `req` low, `rsp_valid` is 0 and `rsp_code`, `rsp_paddr`, `rsp_rd_ok` and `rsp_wr_ok` are all 0.
- R3: An entry matches when its stored pair tag equals `req_vaddr[31:13]` and, in addition, either its global bit is 1 or its stored identifier equals `cur_asid`.
- R4: On a match, `req_vaddr[12]` selects the half: 1 selects the odd half and 0 selects the even half.
- R5: If the selected half is not valid, `rsp_code` is 2 (invalid).
- R6: If the selected half is valid and the access is a read, or it is a write to a dirty half, then `rsp_code` is 0 (hit). In that case `rsp_paddr` is {frame, `req_vaddr[11:0]`}, `rsp_rd_ok` is 1, and `rsp_wr_ok` equals the half's dirty bit.
- R7: A write (`req_write`=1) to a valid half whose dirty bit is 0 gives `rsp_code` 3 (modified fault).
- R8: If no entry matches, `rsp_code` is 1 (no match).
- R9: If several entries match, the entry with the lowest index is used.
- R10: A write strobe replaces every field of the entry at `wr_idx`. The new contents apply to lookups sampled on any later edge.
- R11: For any result code other than 0, `rsp_paddr`, `rsp_rd_ok` and `rsp_wr_ok` are all 0.

The code value 4 is reserved for a bad-address result that an outer address-segment stage produces. This block never emits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Index of the entry to replace |
| wr_vpn2 | input | 19 | Pair tag (virtual address bits 31:13) |
| wr_asid | input | 8 | Entry address-space identifier |
| wr_global | input | 1 | Entry matches any identifier |
| wr_pfn_even | input | 20 | Frame number of the even half |
| wr_valid_even | input | 1 | Even half valid |
| wr_dirty_even | input | 1 | Even half writable |
| wr_pfn_odd | input | 20 | Frame number of the odd half |
| wr_valid_odd | input | 1 | Odd half valid |
| wr_dirty_odd | input | 1 | Odd half writable |
| req | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load access |
| cur_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Response registers hold a lookup result |
| rsp_code | output | 3 | 0 hit, 1 no match, 2 invalid, 3 modified fault |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_rd_ok | output | 1 | Read permission |
| rsp_wr_ok | output | 1 | Write permission |

## Verification
The bench uses the even/odd select bit in both directions on one entry. A design that reads the wrong address bit would return the other half's frame. It also writes to a clean valid half: a design that only checks the valid bit would report a hit where a modified fault is expected. Two tests cover identifier handling. A global entry is looked up with a foreign identifier, and a private entry is looked up with a wrong identifier. Swapping or dropping the global term turns one of these two results around. Two entries are loaded with the same tag, and the bench checks that the lower index wins. A selector that scans from the top would return the other frame. The lower entry is then overwritten, and the bench checks that the higher one takes over.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [2:0] {
        RES_HIT      = 3'd0,
        RES_MISS     = 3'd1,
        RES_INVALID  = 3'd2,
        RES_MODIFIED = 3'd3,
        RES_BADADDR  = 3'd4
    } tlb_res_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } tlb_state_e;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
    parameter int N      = 16,
    parameter int IDX_W  = 4,
    parameter int VPN2_W = 19,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [VPN2_W-1:0]            wr_vpn2,
    input  logic [ASID_W-1:0]            wr_asid,
    input  logic                         wr_global,
    input  logic [PFN_W-1:0]             wr_pfn_even,
    input  logic                         wr_valid_even,
    input  logic                         wr_dirty_even,
    input  logic [PFN_W-1:0]             wr_pfn_odd,
    input  logic                         wr_valid_odd,
    input  logic                         wr_dirty_odd,
    output logic [N-1:0][VPN2_W-1:0]     tag_q,
    output logic [N-1:0][ASID_W-1:0]     asid_q,
    output logic [N-1:0]                 glob_q,
    output logic [N-1:0][PFN_W-1:0]      pfn_even_q,
    output logic [N-1:0]                 v_even_q,
    output logic [N-1:0]                 d_even_q,
    output logic [N-1:0][PFN_W-1:0]      pfn_odd_q,
    output logic [N-1:0]                 v_odd_q,
    output logic [N-1:0]                 d_odd_q
);

    for (genvar e = 0; e < N; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[e]      <= '0;
                asid_q[e]     <= '0;
                glob_q[e]     <= 1'b0;
                pfn_even_q[e] <= '0;
                v_even_q[e]   <= 1'b0;
                d_even_q[e]   <= 1'b0;
                pfn_odd_q[e]  <= '0;
                v_odd_q[e]    <= 1'b0;
                d_odd_q[e]    <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                tag_q[e]      <= wr_vpn2;
                asid_q[e]     <= wr_asid;
                glob_q[e]     <= wr_global;
                pfn_even_q[e] <= wr_pfn_even;
                v_even_q[e]   <= wr_valid_even;
                d_even_q[e]   <= wr_dirty_even;
                pfn_odd_q[e]  <= wr_pfn_odd;
                v_odd_q[e]    <= wr_valid_odd;
                d_odd_q[e]    <= wr_dirty_odd;
            end
        end
    end

    // R10
    entry_replaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tag_q[$past(wr_idx)] == $past(wr_vpn2)) &&
                  (pfn_odd_q[$past(wr_idx)] == $past(wr_pfn_odd)));

endmodule

// File: rtl/tlb_match_array.sv
module tlb_match_array #(
    parameter int N      = 16,
    parameter int VPN2_W = 19,
    parameter int ASID_W = 8
) (
    input  logic [N-1:0][VPN2_W-1:0] tag_q,
    input  logic [N-1:0][ASID_W-1:0] asid_q,
    input  logic [N-1:0]             glob_q,
    input  logic [VPN2_W-1:0]        look_vpn2,
    input  logic [ASID_W-1:0]        look_asid,
    output logic [N-1:0]             hit_vec
);

    for (genvar e = 0; e < N; e++) begin : g_cmp
        assign hit_vec[e] = (tag_q[e] == look_vpn2) &&
                            (glob_q[e] || (asid_q[e] == look_asid));
    end

endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     hit_vec,
    output logic [IDX_W-1:0] sel_idx,
    output logic [N-1:0]     sel_oh,
    output logic             any_hit
);

    always_comb begin
        sel_idx = '0;
        sel_oh  = '0;
        any_hit = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_idx = IDX_W'(i);
                sel_oh  = '0;
                sel_oh[i] = 1'b1;
                any_hit = 1'b1;
            end
        end
    end

    // R9
    always_comb begin
        lowest_wins_chk: assert (((sel_oh - 1'b1) & hit_vec & {N{any_hit}}) == '0);
        sel_subset_chk: assert ($onehot0(sel_oh) && ((sel_oh & ~hit_vec) == '0));
    end

endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
    import tlb_pkg::*;
#(
    parameter int N         = 16,
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    localparam int IDX_W    = $clog2(N),
    localparam int VPN2_W   = VA_W - PAGE_BITS - 1,
    localparam int PFN_W    = VA_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic              wr_valid_even,
    input  logic              wr_dirty_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_valid_odd,
    input  logic              wr_dirty_odd,
    input  logic              req,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic              rsp_rd_ok,
    output logic              rsp_wr_ok
);

    logic [N-1:0][VPN2_W-1:0] tag_q;
    logic [N-1:0][ASID_W-1:0] asid_q;
    logic [N-1:0]             glob_q;
    logic [N-1:0][PFN_W-1:0]  pfn_even_q;
    logic [N-1:0]             v_even_q;
    logic [N-1:0]             d_even_q;
    logic [N-1:0][PFN_W-1:0]  pfn_odd_q;
    logic [N-1:0]             v_odd_q;
    logic [N-1:0]             d_odd_q;
    logic [N-1:0]             hit_vec;
    logic [N-1:0]             sel_oh;
    logic [IDX_W-1:0]         sel_idx;
    logic                     any_hit;

    tlb_entry_store #(.N(N), .IDX_W(IDX_W), .VPN2_W(VPN2_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_pfn_even(wr_pfn_even), .wr_valid_even(wr_valid_even), .wr_dirty_even(wr_dirty_even),
        .wr_pfn_odd(wr_pfn_odd), .wr_valid_odd(wr_valid_odd), .wr_dirty_odd(wr_dirty_odd),
        .tag_q(tag_q), .asid_q(asid_q), .glob_q(glob_q),
        .pfn_even_q(pfn_even_q), .v_even_q(v_even_q), .d_even_q(d_even_q),
        .pfn_odd_q(pfn_odd_q), .v_odd_q(v_odd_q), .d_odd_q(d_odd_q)
    );

    tlb_match_array #(.N(N), .VPN2_W(VPN2_W), .ASID_W(ASID_W)) u_match (
        .tag_q(tag_q), .asid_q(asid_q), .glob_q(glob_q),
        .look_vpn2(req_vaddr[VA_W-1:PAGE_BITS+1]), .look_asid(cur_asid),
        .hit_vec(hit_vec)
    );

    tlb_prio_sel #(.N(N), .IDX_W(IDX_W)) u_prio (
        .hit_vec(hit_vec), .sel_idx(sel_idx), .sel_oh(sel_oh), .any_hit(any_hit)
    );

    // Combinational evaluation of the selected half
    logic             odd_half;
    logic [PFN_W-1:0] half_pfn;
    logic             half_v;
    logic             half_d;
    tlb_res_e         res_d;
    logic [VA_W-1:0]  pa_d;
    logic             rd_d;
    logic             wr_d;

    always_comb begin
        odd_half = req_vaddr[PAGE_BITS];
        half_pfn = odd_half ? pfn_odd_q[sel_idx] : pfn_even_q[sel_idx];
        half_v   = odd_half ? v_odd_q[sel_idx]   : v_even_q[sel_idx];
        half_d   = odd_half ? d_odd_q[sel_idx]   : d_even_q[sel_idx];
        res_d    = RES_MISS;
        pa_d     = '0;
        rd_d     = 1'b0;
        wr_d     = 1'b0;
        if (any_hit) begin
            if (!half_v) begin
                res_d = RES_INVALID;
            end else if (req_write && !half_d) begin
                res_d = RES_MODIFIED;
            end else begin
                res_d = RES_HIT;
                pa_d  = {half_pfn, req_vaddr[PAGE_BITS-1:0]};
                rd_d  = 1'b1;
                wr_d  = half_d;
            end
        end
    end

    // State register
    tlb_state_e state_q;
    tlb_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)  state_d = ST_RESP;
            ST_RESP: if (!req) state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_code  <= '0;
            rsp_paddr <= '0;
            rsp_rd_ok <= 1'b0;
            rsp_wr_ok <= 1'b0;
        end else if (req) begin
            rsp_code  <= res_d;
            rsp_paddr <= pa_d;
            rsp_rd_ok <= rd_d;
            rsp_wr_ok <= wr_d;
        end else begin
            rsp_code  <= '0;
            rsp_paddr <= '0;
            rsp_rd_ok <= 1'b0;
            rsp_wr_ok <= 1'b0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    // R2
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);
    // R2
    rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid && (rsp_code == 3'd0) && !rsp_rd_ok);
    // R6
    hit_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd0) |-> rsp_rd_ok);
    // R11
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != 3'd0) |-> (rsp_paddr == '0) && !rsp_rd_ok && !rsp_wr_ok);
    // R6
    write_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_ok |-> rsp_valid && rsp_rd_ok);

endmodule

// File: tb/tlb_pair_lookup_bench.sv
module tlb_pair_lookup_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn_even = '0;
    logic        wr_valid_even = 1'b0;
    logic        wr_dirty_even = 1'b0;
    logic [19:0] wr_pfn_odd = '0;
    logic        wr_valid_odd = 1'b0;
    logic        wr_dirty_odd = 1'b0;
    logic        req = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_code;
    logic [31:0] rsp_paddr;
    logic        rsp_rd_ok;
    logic        rsp_wr_ok;

    int applied = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    tlb_pair_lookup u_tlb_pair_lookup (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_pfn_even(wr_pfn_even), .wr_valid_even(wr_valid_even), .wr_dirty_even(wr_dirty_even),
        .wr_pfn_odd(wr_pfn_odd), .wr_valid_odd(wr_valid_odd), .wr_dirty_odd(wr_dirty_odd),
        .req(req), .req_vaddr(req_vaddr), .req_write(req_write), .cur_asid(cur_asid),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
        .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok)
    );

    task automatic load(input logic [3:0] idx, input logic [18:0] vpn2, input logic [7:0] asid,
                        input logic g, input logic [19:0] pe, input logic ve, input logic de,
                        input logic [19:0] po, input logic vo, input logic dd);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn2 = vpn2; wr_asid = asid; wr_global = g;
        wr_pfn_even = pe; wr_valid_even = ve; wr_dirty_even = de;
        wr_pfn_odd = po; wr_valid_odd = vo; wr_dirty_odd = dd;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Lookup: req high for one edge, sample 1 ns after that edge, then check the drop.
    task automatic lookup(input string rq, input logic [31:0] va, input logic wr, input logic [7:0] asid,
                          input logic [2:0] ecode, input logic [31:0] epa, input logic erd, input logic ewr);
        @(negedge clk);
        req = 1'b1; req_vaddr = va; req_write = wr; cur_asid = asid;
        @(posedge clk);
        #1;
        applied++;
        if (rsp_valid !== 1'b1 || rsp_code !== ecode || rsp_paddr !== epa ||
            rsp_rd_ok !== erd || rsp_wr_ok !== ewr) begin
            errors++;
            $display("FAIL %s va=%h: got v=%b code=%0d pa=%h rd=%b wr=%b, expected v=1 code=%0d pa=%h rd=%b wr=%b",
                     rq, va, rsp_valid, rsp_code, rsp_paddr, rsp_rd_ok, rsp_wr_ok, ecode, epa, erd, ewr);
        end
        @(negedge clk);
        req = 1'b0;
        @(posedge clk);
        #1;
        applied++;
        if (rsp_valid !== 1'b0 || rsp_code !== 3'd0 || rsp_paddr !== 32'd0 || rsp_rd_ok !== 1'b0) begin
            errors++;
            $display("FAIL R2 drop after %s: got v=%b code=%0d pa=%h rd=%b, expected v=0 code=0 pa=0 rd=0",
                     rq, rsp_valid, rsp_code, rsp_paddr, rsp_rd_ok);
        end
    endtask

    task automatic t_reset;
        #1;
        applied++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 rsp_valid in reset: got %b expected 0", rsp_valid);
        end
        // R1, R8: cleared entries match nothing outside pair 0
        lookup("R1/R8 empty", 32'h1234_5678, 1'b0, 8'h00, 3'd1, 32'd0, 1'b0, 1'b0);
        // R1: entry 0 holds tag 0 but is not valid
        lookup("R1/R5 cleared entry", 32'h0000_0010, 1'b0, 8'h00, 3'd2, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic t_pair_select;
        load(4'd3, 19'h00201, 8'h05, 1'b0, 20'hABCDE, 1'b1, 1'b0, 20'h12345, 1'b1, 1'b1);
        lookup("R4/R6 even read", 32'h0040_2ABC, 1'b0, 8'h05, 3'd0, 32'hABCD_EABC, 1'b1, 1'b0);
        lookup("R4/R6 odd read",  32'h0040_3123, 1'b0, 8'h05, 3'd0, 32'h1234_5123, 1'b1, 1'b1);
        lookup("R6 odd write",    32'h0040_3FFF, 1'b1, 8'h05, 3'd0, 32'h1234_5FFF, 1'b1, 1'b1);
    endtask

    task automatic t_modified;
        lookup("R7 clean write",  32'h0040_2004, 1'b1, 8'h05, 3'd3, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic t_identifier;
        lookup("R3 asid mismatch", 32'h0040_2004, 1'b0, 8'h06, 3'd1, 32'd0, 1'b0, 1'b0);
        lookup("R3 neighbour tag", 32'h0040_4000, 1'b0, 8'h05, 3'd1, 32'd0, 1'b0, 1'b0);
        load(4'd7, 19'h00300, 8'h09, 1'b1, 20'h00000, 1'b0, 1'b0, 20'h00077, 1'b1, 1'b0);
        lookup("R3/R5 global even invalid", 32'h0060_0000, 1'b0, 8'h02, 3'd2, 32'd0, 1'b0, 1'b0);
        lookup("R3 global odd read", 32'h0060_1FFF, 1'b0, 8'h02, 3'd0, 32'h0007_7FFF, 1'b1, 1'b0);
    endtask

    task automatic t_priority;
        load(4'd10, 19'h00400, 8'h01, 1'b0, 20'hAAAAA, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
        load(4'd2,  19'h00400, 8'h01, 1'b0, 20'h22222, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
        lookup("R9 lowest index", 32'h0080_0345, 1'b1, 8'h01, 3'd0, 32'h2222_2345, 1'b1, 1'b1);
        load(4'd2,  19'h00500, 8'h01, 1'b0, 20'h22222, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
        lookup("R10/R9 overwrite lower", 32'h0080_0345, 1'b0, 8'h01, 3'd0, 32'hAAAA_A345, 1'b1, 1'b1);
    endtask

    task automatic t_replace;
        load(4'd3, 19'h00201, 8'h05, 1'b0, 20'hABCDE, 1'b1, 1'b0, 20'h12345, 1'b0, 1'b1);
        lookup("R10/R5 odd now invalid", 32'h0040_3123, 1'b0, 8'h05, 3'd2, 32'd0, 1'b0, 1'b0);
        lookup("R10 even kept",          32'h0040_2000, 1'b0, 8'h05, 3'd0, 32'hABCD_E000, 1'b1, 1'b0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end

    initial begin
        t_reset_pre: begin
            #12 rst_n = 1'b1;
        end
        @(negedge clk);
        t_reset;
        t_pair_select;
        t_modified;
        t_identifier;
        t_priority;
        t_replace;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule